// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Layered Write Lock

This block is a synthesizable slave for a two-wire serial bus that stores 256 bytes. Bus clock and data are sampled on the system clock. The block finds START and STOP conditions and accepts a seven-bit device address built from a fixed four-bit identifier and three strap inputs. It acknowledges bytes and supports single-byte writes, page writes of up to sixteen bytes, current-address reads, random reads and sequential reads. All of these share one word-address counter that advances by itself.

A write is gathered in a page buffer and committed to the array at STOP. A self-timed busy period of `WR_CYCLES` clocks follows. While it runs, the slave ignores its own address.

Three write-lock sources are layered. A pin blocks every write. Two software lock flags each shield the lower half of the array. One flag is permanent and the other can be cleared, and both are driven through simple pulse inputs. The data line is modelled as an open-drain pull-down enable.

Top module: `eeprom_2w`

## Requirements
- R1: After reset the pull-down output is 0 (line released), and it stays 0 until an addressed transfer starts.
- R2: The first byte after START is matched as bits [7:4] = DEV_ID (default 4'b1010), bits [3:1] = strap_i, bit 0 = direction (1 = read). Only on a full match does the slave pull the line low in the ninth clock. On a mismatch it stays released until the next START or STOP.
- R3: A write transfer (device byte, word address, one data byte, STOP) stores the byte at that address, and a later read returns it.
- R4: A page write stores up to 16 bytes. The low 4 address bits advance and wrap inside the 16-byte page while the high 4 bits stay fixed.
- R5: Reads return bytes MSB first from the word-address counter. The full 8-bit counter advances after every byte sent and wraps from FFh to 00h. A current-address read returns the byte after the last one sent.
- R6: A STOP that ends a write with at least one stored byte starts a busy period of WR_CYCLES clocks. During this period the device byte is not acknowledged, and afterwards it is.
- R7: While wp_pin_i is 1, no write changes the array. Data bytes are still acknowledged, and no busy period starts.
- R8: With wp_pin_i at 0 and either lock flag set, writes to 00h–7Fh are dropped and writes to 80h–FFh proceed.
- R9: A pulse on lock_rev_clr_i clears the reversible flag and restores writes to 00h–7Fh. After the permanent flag is set, no input other than reset clears it.
- R10: The slave only pulls the line low or releases it, and it changes the pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved bus data level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device address straps |
| wp_pin_i | input | 1 | 1 blocks all writes |
| lock_perm_set_i | input | 1 | Pulse: set the permanent lower-half lock |
| lock_rev_set_i | input | 1 | Pulse: set the reversible lower-half lock |
| lock_rev_clr_i | input | 1 | Pulse: clear the reversible lower-half lock |

## Verification
Each bus level goes through a two-flop synchroniser and one edge register. As a result, the pull-down answers three clocks after an SCL falling edge, well inside the six-clock low phase. The bench reads acknowledges and read bits in the middle of the SCL high phase, nine clocks after the fall.

Array contents become visible once the STOP is detected. The busy period lasts WR_CYCLES clocks from that point. The bench therefore probes the device address at once to expect a NACK, then waits WR_CYCLES plus a margin before it expects an ACK.

// File: rtl/eep_pkg.sv
// Shared types for the two-wire memory slave.
package eep_pkg;

    // Protocol phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } eep_state_e;

endpackage

// File: rtl/eep_bus_edge.sv
// Bus sampler: synchronises SCL and SDA into clk and flags edges and
// START/STOP. Assumes the bus is far slower than clk (several clocks per phase).
module eep_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    // Two-flop synchroniser plus one history stage per line; idle bus is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_lvl   = scl_q[1];
    assign sda_lvl   = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign bus_start = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign bus_stop  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

endmodule

// File: rtl/eep_wr_timer.sv
// Self-timed write period: a load pulse starts a down-count of WR_CYCLES
// clocks, and busy is high until it reaches zero.
module eep_wr_timer #(
    parameter int WR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    logic [CW-1:0] cnt;

    // Load on kick, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (kick)    cnt <= CW'(WR_CYCLES);
        else if (cnt != 0) cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

    // R6: busy time shrinks by exactly one clock per cycle until done
    p_busy_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !kick) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/eep_wp.sv
// Write-lock logic: holds the permanent and reversible lower-half lock flags
// and decides whether a byte at addr may be stored. Assumes pulse inputs.
module eep_wp #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_pin,
    input  logic          perm_set,
    input  logic          rev_set,
    input  logic          rev_clr,
    input  logic [AW-1:0] addr,
    output logic          wr_ok
);
    logic perm_lock;
    logic rev_lock;

    // Permanent flag only ever sets; reversible flag sets and clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm_lock <= 1'b0;
            rev_lock  <= 1'b0;
        end else begin
            if (perm_set) perm_lock <= 1'b1;
            if (rev_set)       rev_lock <= 1'b1;
            else if (rev_clr)  rev_lock <= 1'b0;
        end
    end

    // Lower half is the range with the top address bit clear
    assign wr_ok = !wp_pin && !(!addr[AW-1] && (perm_lock || rev_lock));

    // R9: the permanent flag never falls once set
    p_perm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        perm_lock |=> perm_lock);

endmodule

// File: rtl/eeprom_2w.sv
// Two-wire serial memory slave, 2**AW bytes, pages of 2**PW bytes.
// Assumes SCL/SDA are slow against clk; sda_i is the resolved wired-AND level.
// Writes gather in a page buffer and commit at STOP, then a busy period runs.
module eeprom_2w #(
    parameter int         AW        = 8,
    parameter int         PW        = 4,
    parameter int         WR_CYCLES = 500,
    parameter logic [3:0] DEV_ID    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] strap_i,
    input  logic       wp_pin_i,
    input  logic       lock_perm_set_i,
    input  logic       lock_rev_set_i,
    input  logic       lock_rev_clr_i
);
    import eep_pkg::*;

    localparam int          DEPTH = 1 << AW;
    localparam int          PG    = 1 << PW;
    localparam logic [3:0]  BITS  = 4'd8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic busy, wr_ok;

    eep_state_e        state;
    logic [3:0]        bit_cnt;
    logic              ack_ph;
    logic [7:0]        shreg;
    logic [7:0]        out_sh;
    logic [AW-1:0]     addr_cnt;
    logic              rw;
    logic              sda_pull;
    logic [PG-1:0]     pg_mask;
    logic [AW-PW-1:0]  pg_hi;
    logic [7:0]        pg_buf [PG];
    logic [7:0]        mem    [DEPTH];
    logic [7:0]        rd_byte;

    eep_bus_edge u_edge (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    eep_wp #(.AW(AW)) u_wp (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin_i),
        .perm_set(lock_perm_set_i), .rev_set(lock_rev_set_i),
        .rev_clr(lock_rev_clr_i), .addr(addr_cnt), .wr_ok(wr_ok)
    );

    logic commit;
    eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
    );

    logic rx_state, byte_done, ack_end, dev_hit, wr_take;
    assign rx_state  = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
    assign byte_done = rx_state && scl_fall && !ack_ph && (bit_cnt == BITS);
    assign ack_end   = rx_state && scl_fall && ack_ph;
    assign dev_hit   = (shreg[7:1] == {DEV_ID, strap_i}) && !busy;
    assign wr_take   = byte_done && (state == ST_WDATA) && wr_ok;
    assign commit    = bus_stop && (state == ST_WDATA) && (pg_mask != '0);
    assign rd_byte   = mem[addr_cnt];
    assign sda_pull_o = sda_pull;

    // Protocol engine: bit shifting, acknowledges, address counter, read output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            shreg    <= '0;
            out_sh   <= '0;
            addr_cnt <= '0;
            rw       <= 1'b0;
            sda_pull <= 1'b0;
            pg_mask  <= '0;
            pg_hi    <= '0;
        end else if (bus_start || bus_stop) begin
            state    <= bus_start ? ST_DEV : ST_IDLE;
            bit_cnt  <= '0;
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            pg_mask  <= '0;
        end else if (rx_state) begin
            if (scl_rise && !ack_ph && bit_cnt != BITS) begin
                shreg   <= {shreg[6:0], sda_lvl};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (byte_done) begin
                case (state)
                    ST_DEV: begin
                        if (dev_hit) begin
                            rw       <= shreg[0];
                            ack_ph   <= 1'b1;
                            sda_pull <= 1'b1;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_WORD: begin
                        addr_cnt <= shreg[AW-1:0];
                        ack_ph   <= 1'b1;
                        sda_pull <= 1'b1;
                    end
                    default: begin
                        if (wr_ok) begin
                            pg_mask[addr_cnt[PW-1:0]] <= 1'b1;
                            pg_hi <= addr_cnt[AW-1:PW];
                        end
                        addr_cnt <= {addr_cnt[AW-1:PW], addr_cnt[PW-1:0] + 1'b1};
                        ack_ph   <= 1'b1;
                        sda_pull <= 1'b1;
                    end
                endcase
            end
            if (ack_end) begin
                sda_pull <= 1'b0;
                ack_ph   <= 1'b0;
                bit_cnt  <= '0;
                if (state == ST_DEV && rw) begin
                    state    <= ST_RDATA;
                    out_sh   <= {rd_byte[6:0], 1'b0};
                    sda_pull <= ~rd_byte[7];
                    addr_cnt <= addr_cnt + 1'b1;
                    bit_cnt  <= 4'd1;
                end else if (state == ST_DEV) begin
                    state <= ST_WORD;
                end else if (state == ST_WORD) begin
                    state <= ST_WDATA;
                end
            end
        end else if (state == ST_RDATA) begin
            if (!ack_ph && scl_fall) begin
                if (bit_cnt != BITS) begin
                    sda_pull <= ~out_sh[7];
                    out_sh   <= {out_sh[6:0], 1'b0};
                    bit_cnt  <= bit_cnt + 1'b1;
                end else begin
                    sda_pull <= 1'b0;
                    ack_ph   <= 1'b1;
                end
            end else if (ack_ph && scl_rise && sda_lvl) begin
                state <= ST_SKIP;
            end else if (ack_ph && scl_fall) begin
                out_sh   <= {rd_byte[6:0], 1'b0};
                sda_pull <= ~rd_byte[7];
                addr_cnt <= addr_cnt + 1'b1;
                bit_cnt  <= 4'd1;
                ack_ph   <= 1'b0;
            end
        end
    end

    // Page buffer capture of accepted data bytes
    always_ff @(posedge clk) begin
        if (wr_take) pg_buf[addr_cnt[PW-1:0]] <= shreg;
    end

    // Array update at STOP for every buffered byte of the page
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PG; i++) begin
                if (pg_mask[i]) mem[{pg_hi, PW'(i)}] <= pg_buf[i];
            end
        end
    end

    // R10: pull-down only changes while the sampled clock is low
    p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    // R6: device byte seen during the busy period gets no acknowledge
    p_busy_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_DEV && busy) |=> !sda_pull);

    // R7: with the pin high no data byte enters the page buffer
    p_pin_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_WDATA && wp_pin_i) |=> $stable(pg_mask));

endmodule

// File: tb/eeprom_2w_bench.sv
module eeprom_2w_bench;
    localparam int CLK_P = 10;
    localparam int WRC   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull;
    logic [2:0] strap = 3'b101;
    logic wp = 1'b0, perm_set = 1'b0, rev_set = 1'b0, rev_clr = 1'b0;
    logic sda_bus;
    assign sda_bus = m_sda & ~sda_pull;

    always #(CLK_P/2) clk = ~clk;

    eeprom_2w #(.WR_CYCLES(WRC)) u_eeprom_2w (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .strap_i(strap), .wp_pin_i(wp),
        .lock_perm_set_i(perm_set), .lock_rev_set_i(rev_set),
        .lock_rev_clr_i(rev_clr)
    );

    int tests = 0, fails = 0, hold_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_mem [256];
    bit m_perm = 1'b0, m_rev = 1'b0;

    task automatic chk(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic w(int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 monitor: pull-down must stay put while SCL is high
    logic prev_scl = 1'b1, prev_pull = 1'b0;
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && sda_pull != prev_pull) hold_viol++;
        prev_scl  <= m_scl;
        prev_pull <= sda_pull;
    end

    task automatic b_start();
        w(3); m_sda = 1'b1; w(3); m_scl = 1'b1; w(6); m_sda = 1'b0; w(6); m_scl = 1'b0;
    endtask
    task automatic b_stop();
        w(3); m_sda = 1'b0; w(3); m_scl = 1'b1; w(6); m_sda = 1'b1; w(6);
    endtask
    task automatic send_bit(logic b);
        w(3); m_sda = b; w(3); m_scl = 1'b1; w(6); m_scl = 1'b0;
    endtask
    task automatic recv_bit(output logic b);
        w(3); m_sda = 1'b1; w(3); m_scl = 1'b1; w(3); b = sda_bus; w(3); m_scl = 1'b0;
    endtask
    task automatic send_byte(logic [7:0] d, output logic nak);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(nak);
    endtask
    task automatic recv_byte(logic nak, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(nak);
    endtask

    function automatic logic [7:0] dev(logic rd);
        return {4'b1010, strap, rd};
    endfunction
    function automatic logic [7:0] pat(int a, int seed);
        return 8'((a * 5 + seed) ^ 8'h3C);
    endfunction
    function automatic bit allowed(int a);
        return !wp && !(a < 128 && (m_perm || m_rev));
    endfunction

    // Page/byte write with model update and busy/ready probing (R3 R4 R6 R7)
    task automatic wr(int addr, int n, int seed, string req);
        logic nak;
        bit any = 1'b0;
        b_start();
        send_byte(dev(1'b0), nak);  chk(nak == 1'b0, req, nak, 0);
        send_byte(8'(addr), nak);   chk(nak == 1'b0, req, nak, 0);
        for (int i = 0; i < n; i++) begin
            int a = (addr & 8'hF0) | ((addr + i) & 4'hF);
            send_byte(pat(a, seed), nak);
            chk(nak == 1'b0, {req, " data ack R7"}, nak, 0);
            if (allowed(a)) begin exp_mem[a] = pat(a, seed); any = 1'b1; end
        end
        b_stop();
        b_start(); send_byte(dev(1'b0), nak); b_stop();
        if (any) begin
            chk(nak == 1'b1, "R6 busy nack", nak, 1);
            w(WRC + 20);
            b_start(); send_byte(dev(1'b0), nak); b_stop();
            chk(nak == 1'b0, "R6 ready ack", nak, 0);
        end else begin
            chk(nak == 1'b0, "R7 no busy after blocked write", nak, 0);
        end
    endtask

    // Random then sequential read, compared with the model (R5)
    task automatic rd(int addr, int n, string req);
        logic nak;
        logic [7:0] d;
        b_start();
        send_byte(dev(1'b0), nak);
        send_byte(8'(addr), nak);
        b_start();
        send_byte(dev(1'b1), nak);  chk(nak == 1'b0, req, nak, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            chk(d == exp_mem[(addr + i) & 8'hFF], req, d, exp_mem[(addr + i) & 8'hFF]);
        end
        b_stop();
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) perm_set = 1'b1; else if (which == 1) rev_set = 1'b1; else rev_clr = 1'b1;
        @(negedge clk);
        perm_set = 1'b0; rev_set = 1'b0; rev_clr = 1'b0;
    endtask

    initial begin
        logic nak;
        logic [7:0] d;
        w(4); rst_n = 1'b1; w(2);
        chk(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);
        w(20);
        chk(sda_pull == 1'b0, "R1 released while idle", sda_pull, 0);

        // R2: sweep all strap codes, only the wired one answers
        for (int s = 0; s < 8; s++) begin
            b_start(); send_byte({4'b1010, 3'(s), 1'b0}, nak); b_stop();
            chk(nak == (s != 5), "R2 strap match", nak, (s != 5));
        end
        b_start(); send_byte({4'b1011, strap, 1'b0}, nak); b_stop();
        chk(nak == 1'b1, "R2 wrong identifier", nak, 1);

        // R4: fill the whole array page by page
        for (int p = 0; p < 16; p++) wr(p * 16, 16, 0, "R4 page fill");
        // R5: read all 256 plus one more to see the wrap to 00h
        rd(0, 257, "R5 sequential wrap");
        b_start(); send_byte(dev(1'b1), nak); recv_byte(1'b1, d); b_stop();
        chk(d == exp_mem[1], "R5 current address read", d, exp_mem[1]);

        // R4: partial page that crosses the page end wraps inside it
        wr(8'h2E, 4, 8'h50, "R4 page wrap");
        rd(8'h20, 16, "R4 page wrap readback");
        // R3: single byte
        wr(8'h91, 1, 8'h11, "R3 byte write");
        rd(8'h91, 1, "R3 byte readback");

        // R7: pin blocks both halves
        wp = 1'b1;
        wr(8'h05, 2, 8'h77, "R7 pin low half");
        wr(8'h85, 2, 8'h77, "R7 pin high half");
        wp = 1'b0;
        rd(8'h05, 2, "R7 low half unchanged");
        rd(8'h85, 2, "R7 high half unchanged");

        // R8: reversible lock shields only the lower half
        pulse(1); m_rev = 1'b1;
        wr(8'h10, 1, 8'h21, "R8 lower half locked");
        wr(8'h90, 1, 8'h21, "R8 upper half open");
        rd(8'h10, 1, "R8 lower readback");
        rd(8'h90, 1, "R8 upper readback");
        // R9: clear restores the lower half
        pulse(2); m_rev = 1'b0;
        wr(8'h10, 1, 8'h33, "R9 after clear");
        rd(8'h10, 1, "R9 after clear readback");
        // R9: permanent lock survives a clear pulse
        pulse(0); m_perm = 1'b1;
        pulse(2);
        wr(8'h11, 1, 8'h44, "R9 permanent lock holds");
        wr(8'hA0, 1, 8'h44, "R8 upper half with permanent lock");
        rd(8'h11, 1, "R9 permanent readback");
        rd(8'hA0, 1, "R8 upper readback permanent");

        chk(hold_viol == 0, "R10 pull-down stable while SCL high", hold_viol, 0);
        chk(sda_pull == 1'b0, "R1 released at end", sda_pull, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule